// File: doc/BRIEF.md
# Tiered Interrupt Status Encoder

This block gathers interrupt requests from three tiers (critical, main and peripheral) and produces one registered 32-bit status word. A processor reads this word to decide which source to service. Each tier has its own valid flag and its own encoded source number. Software reads the tiers in a fixed order: critical first, then main, then peripheral.

Two tier slots do not come from pins. They cascade to the peripheral tier:

- Critical slot 2 is active while any unmasked high-class peripheral is requesting.
- Main slot 4 is active while any unmasked low-class peripheral is requesting.

Peripheral source 0 is itself a cascade from a DMA pending vector. When it is reported, the `dma_chan` output gives the lowest pending DMA channel.

Main and peripheral sources each have a mask bit, in which 1 means disabled. The masks are loaded through a simple write port. Critical requests on slots 0, 1 and 3 are edge-latched. Each one stays pending until software acknowledges it.

The block has no state machine. All of its state is the mask bank, the critical pending latches, the edge-detect flops and the two output registers.

Top module: `isr_status_enc`

## Requirements
- R1: While reset is asserted, and after it is released, `status` and `dma_chan` are 0. Both masks come out of reset with every bit set, so no main or peripheral source can raise a valid flag until a mask is written.
- R2: A write with `cfg_we`=1 and `cfg_sel`=0 loads the main mask from `cfg_wdata[16:0]`. Main slot k is disabled by mask bit (16−k) being 1.
- R3: A write with `cfg_we`=1 and `cfg_sel`=1 loads the peripheral mask from `cfg_wdata[31:1]`. Peripheral source k is disabled by mask bit (31−k) being 1. `cfg_wdata[0]` has no effect on the peripheral mask.
- R4: `status[21]` is 1 exactly when some unmasked main slot is active. `status[20:16]` then holds the lowest such slot number. Slots are fed as follows:
  - slots 0–3 from `main_req[3:0]`;
  - slots 5–16 from `main_req[15:4]`;
  - slot 4 from the cascade in R6.
- R5: `status[29]` is 1 exactly when some unmasked peripheral source is active. Peripheral source 0 is active when any `dma_pend` bit is set, and source k (1–30) is fed from `per_req[k−1]`. `status[28:24]` holds the lowest active high-class source number if there is one, otherwise the lowest active low-class number. With default parameters, sources 0–7 are high class.
- R6: Critical slot 2 is active while any unmasked high-class peripheral is active. Main slot 4 is active while any unmasked low-class peripheral is active, and it is still subject to main mask bit 12.
- R7: A rising edge on `crit_req[0]`, `crit_req[1]` or `crit_req[2]` latches a pending request for critical slot 0, 1 or 3 respectively. `status[10]` is 1 exactly when a critical slot is active, and `status[9:8]` holds the lowest active slot.
- R8: A pulse on `ack_we` with `ack_crit`=1 clears the pending latch of the critical slot that `status` currently reports, when that slot is 0, 1 or 3. With `ack_crit`=0 the pulse has no effect.
- R9: Main, peripheral and DMA fields reflect inputs and masks one clock after they change. A critical request appears two clocks after its rising edge.
- R10: `dma_chan` is the registered index of the lowest set bit of `dma_pend`, and 0 when none is set.
- R11: All `status` bits outside bits 29:24, 21:16 and 10:8 read 0. Each number field reads 0 while its valid flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crit_req | input | 3 | Critical request lines for slots 0, 1 and 3 |
| main_req | input | 16 | Main request lines for slots 0–3 and 5–16 |
| per_req | input | 30 | Peripheral request lines for sources 1–30 |
| dma_pend | input | DMA_N | DMA pending vector (cascade into peripheral source 0) |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | Mask select: 0 = main, 1 = peripheral |
| cfg_wdata | input | 32 | Mask write data |
| ack_we | input | 1 | Status acknowledge strobe |
| ack_crit | input | 1 | Value written at the critical-valid bit position |
| status | output | 32 | Registered encoded status word |
| dma_chan | output | log2(DMA_N) | Lowest pending DMA channel |

## Verification
Several relations are checked every cycle inside the RTL:
- a reported critical slot 2 always comes with a high-class peripheral number;
- a reported main slot 4 always comes with a valid peripheral tier;
- a reported peripheral 0 implies DMA pending bits in the previous cycle;
- an acknowledge clears the latch it targets;
- the masks hold between writes.

Other behaviours can only be shown by the bench scenarios, because they depend on what the inputs and mask contents were:
- which source wins inside each tier;
- the reversed mask bit order;
- the high-class-first rule;
- the two-clock critical latency;
- an acknowledge written with the bit clear having no effect.

// File: rtl/isc_pkg.sv
package isc_pkg;
    localparam int CRIT_N     = 4;
    localparam int MAIN_N     = 17;
    localparam int PER_N      = 31;
    localparam int CRIT_W     = 2;
    localparam int NUM_W      = 5;
    localparam int CRIT_V_BIT = 10;
    localparam int CRIT_LSB   = 8;
    localparam int MAIN_V_BIT = 21;
    localparam int MAIN_LSB   = 16;
    localparam int PER_V_BIT  = 29;
    localparam int PER_LSB    = 24;
    localparam int CRIT_CASC  = 2;
    localparam int MAIN_CASC  = 4;
endpackage

// File: rtl/isc_lowest.sv
module isc_lowest #(
    parameter  int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
    assign hit = |req;
endmodule

// File: rtl/isc_mask_bank.sv
module isc_mask_bank
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    output logic [MAIN_N-1:0] main_en,
    output logic [PER_N-1:0]  per_en
);
    logic [MAIN_N-1:0] main_mask;
    logic [PER_N:1]    per_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mask <= '1;
            per_mask  <= '1;
        end else if (wr_en) begin
            if (wr_sel) per_mask  <= wr_data[PER_N:1];
            else        main_mask <= wr_data[MAIN_N-1:0];
        end
    end

    for (genvar k = 0; k < MAIN_N; k++) begin : g_main
        assign main_en[k] = ~main_mask[MAIN_N-1-k];
    end
    for (genvar k = 0; k < PER_N; k++) begin : g_per
        assign per_en[k] = ~per_mask[PER_N-k];
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(main_mask) && $stable(per_mask)); // R2
endmodule

// File: rtl/isr_status_enc.sv
module isr_status_enc
    import isc_pkg::*;
#(
    parameter  int               DMA_N    = 16,
    parameter  logic [PER_N-1:0] HI_CLASS = 31'h0000_00FF,
    localparam int               DMA_W    = $clog2(DMA_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        crit_req,
    input  logic [MAIN_N-2:0] main_req,
    input  logic [PER_N-2:0]  per_req,
    input  logic [DMA_N-1:0]  dma_pend,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              ack_we,
    input  logic              ack_crit,
    output logic [31:0]       status,
    output logic [DMA_W-1:0]  dma_chan
);
    logic [MAIN_N-1:0] main_en, main_line, main_act;
    logic [PER_N-1:0]  per_en, per_act, per_hi, per_lo;
    logic              hi_any, lo_any, main_any, crit_any, dma_any;
    logic [NUM_W-1:0]  hi_idx, lo_idx, main_idx, per_num;
    logic [CRIT_W-1:0] crit_idx;
    logic [DMA_W-1:0]  dma_idx;
    logic [2:0]        crit_q, crit_pend, crit_rise, crit_clr;
    logic [CRIT_N-1:0] crit_act;
    logic [31:0]       status_d;

    isc_mask_bank u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .main_en (main_en),
        .per_en  (per_en)
    );

    // Peripheral tier: source 0 is the DMA cascade
    assign per_act = {per_req, |dma_pend} & per_en;
    assign per_hi  = per_act & HI_CLASS;
    assign per_lo  = per_act & ~HI_CLASS;

    isc_lowest #(.N(PER_N)) u_hi (.req(per_hi), .hit(hi_any), .idx(hi_idx));
    isc_lowest #(.N(PER_N)) u_lo (.req(per_lo), .hit(lo_any), .idx(lo_idx));
    assign per_num = hi_any ? hi_idx : lo_idx;

    // Main tier: slot 4 carries the low-class peripheral cascade
    assign main_line = {main_req[MAIN_N-2:MAIN_CASC], lo_any, main_req[MAIN_CASC-1:0]};
    assign main_act  = main_line & main_en;
    isc_lowest #(.N(MAIN_N)) u_main (.req(main_act), .hit(main_any), .idx(main_idx));

    // Critical tier: edge-latched slots 0, 1, 3; slot 2 is the high-class cascade
    assign crit_rise = crit_req & ~crit_q;

    always_comb begin
        crit_clr = '0;
        if (ack_we && ack_crit && status[CRIT_V_BIT]) begin
            unique case (status[CRIT_LSB +: CRIT_W])
                2'd0:    crit_clr = 3'b001;
                2'd1:    crit_clr = 3'b010;
                2'd3:    crit_clr = 3'b100;
                default: crit_clr = 3'b000;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q    <= '0;
            crit_pend <= '0;
        end else begin
            crit_q    <= crit_req;
            crit_pend <= (crit_pend & ~crit_clr) | crit_rise;
        end
    end

    assign crit_act = {crit_pend[2], hi_any, crit_pend[1], crit_pend[0]};
    isc_lowest #(.N(CRIT_N)) u_crit (.req(crit_act), .hit(crit_any), .idx(crit_idx));

    isc_lowest #(.N(DMA_N)) u_dma (.req(dma_pend), .hit(dma_any), .idx(dma_idx));

    always_comb begin
        status_d = '0;
        status_d[CRIT_V_BIT]               = crit_any;
        status_d[CRIT_LSB +: CRIT_W]       = crit_idx;
        status_d[MAIN_V_BIT]               = main_any;
        status_d[MAIN_LSB +: NUM_W]        = main_idx;
        status_d[PER_V_BIT]                = hi_any | lo_any;
        status_d[PER_LSB +: NUM_W]         = per_num;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status   <= '0;
            dma_chan <= '0;
        end else begin
            status   <= status_d;
            dma_chan <= dma_any ? dma_idx : '0;
        end
    end

    AST_CRIT_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (status[CRIT_V_BIT] && status[CRIT_LSB +: CRIT_W] == 2'(CRIT_CASC))
        |-> (status[PER_V_BIT] && HI_CLASS[status[PER_LSB +: NUM_W]])); // R6
    AST_MAIN_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
        (status[MAIN_V_BIT] && status[MAIN_LSB +: NUM_W] == 5'(MAIN_CASC))
        |-> status[PER_V_BIT]); // R6
    AST_DMA_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (status[PER_V_BIT] && status[PER_LSB +: NUM_W] == '0)
        |-> $past(dma_pend) != '0); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && ack_crit && status[CRIT_V_BIT]
         && status[CRIT_LSB +: CRIT_W] == 2'd0 && !crit_req[0])
        |=> !crit_pend[0]); // R8
endmodule

// File: tb/sim_isr_status_enc.sv
module sim_isr_status_enc;
    localparam int DMA_N = 16;
    localparam logic [30:0] HI = 31'h0000_00FF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  crit_req;
    logic [15:0] main_req;
    logic [29:0] per_req;
    logic [DMA_N-1:0] dma_pend;
    logic        cfg_we, cfg_sel, ack_we, ack_crit;
    logic [31:0] cfg_wdata;
    logic [31:0] status;
    logic [3:0]  dma_chan;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model state
    logic [2:0]  pend_m, prev_m;
    logic [16:0] mm_m;
    logic [31:1] pm_m;
    logic [31:0] sts_m;

    always #5 clk = ~clk;

    isr_status_enc u0 (
        .clk(clk), .rst_n(rst_n), .crit_req(crit_req), .main_req(main_req),
        .per_req(per_req), .dma_pend(dma_pend), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ack_we(ack_we), .ack_crit(ack_crit),
        .status(status), .dma_chan(dma_chan)
    );

    function automatic int low_idx(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] ref_status(
        input logic [2:0] pend, input logic [15:0] m, input logic [29:0] p,
        input logic [DMA_N-1:0] d, input logic [16:0] mm, input logic [31:1] pm);
        logic [30:0] pact, hi, lo;
        logic [16:0] mact;
        logic [3:0]  cact;
        logic [31:0] s;
        int pn, mn, cn;
        for (int k = 0; k < 31; k++)
            pact[k] = ((k == 0) ? (d != 0) : p[k-1]) && !pm[31-k];
        hi = pact & HI;
        lo = pact & ~HI;
        pn = (hi != 0) ? low_idx({1'b0, hi}) : low_idx({1'b0, lo});
        for (int k = 0; k < 17; k++)
            mact[k] = ((k == 4) ? (lo != 0) : ((k < 4) ? m[k] : m[k-1])) && !mm[16-k];
        mn = low_idx({15'd0, mact});
        cact = {pend[2], (hi != 0), pend[1], pend[0]};
        cn = low_idx({28'd0, cact});
        s = '0;
        if (cn >= 0) begin s[10] = 1'b1; s[9:8]   = 2'(cn); end
        if (mn >= 0) begin s[21] = 1'b1; s[20:16] = 5'(mn); end
        if (pn >= 0) begin s[29] = 1'b1; s[28:24] = 5'(pn); end
        return s;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, predict, check at the next falling edge
    task automatic step(input logic [2:0] c, input logic [15:0] m, input logic [29:0] p,
                        input logic [DMA_N-1:0] d, input logic cwe, input logic csel,
                        input logic [31:0] cdat, input logic awe, input logic ac,
                        input string tag);
        logic [31:0] exp_s;
        logic [3:0]  exp_d;
        logic [2:0]  clr;
        int dl;
        crit_req = c; main_req = m; per_req = p; dma_pend = d;
        cfg_we = cwe; cfg_sel = csel; cfg_wdata = cdat; ack_we = awe; ack_crit = ac;
        exp_s = ref_status(pend_m, m, p, d, mm_m, pm_m);
        dl = low_idx({16'd0, d});
        exp_d = (dl < 0) ? 4'd0 : 4'(dl);
        clr = 3'b000;
        if (awe && ac && sts_m[10]) begin
            case (sts_m[9:8])
                2'd0: clr = 3'b001;
                2'd1: clr = 3'b010;
                2'd3: clr = 3'b100;
                default: clr = 3'b000;
            endcase
        end
        pend_m = (pend_m & ~clr) | (c & ~prev_m);
        prev_m = c;
        if (cwe) begin
            if (csel) pm_m = cdat[31:1];
            else      mm_m = cdat[16:0];
        end
        sts_m = exp_s;
        @(negedge clk);
        check(tag, "status", status, exp_s);
        check(tag, "dma_chan", {28'd0, dma_chan}, {28'd0, exp_d});
    endtask

    task automatic idle(input string tag);
        step(3'b0, 16'h0, 30'h0, '0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        crit_req = '0; main_req = '0; per_req = '0; dma_pend = '0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = '0; ack_we = 0; ack_crit = 0;
        pend_m = '0; prev_m = '0; mm_m = '1; pm_m = '1; sts_m = '0;
        repeat (3) @(negedge clk);
        check("R1", "status in reset", status, 32'h0);
        check("R1", "dma_chan in reset", {28'd0, dma_chan}, 32'h0);
        rst_n = 1'b1;

        // R1: every main/peripheral line active, masks still all set
        step(3'b0, 16'hFFFF, 30'h3FFF_FFFF, 16'h0001, 0, 0, 0, 0, 0, "R1");
        step(3'b0, 16'hFFFF, 30'h3FFF_FFFF, 16'h0001, 0, 0, 0, 0, 0, "R1");
        check("R1", "no main/per valid", {30'd0, status[29], status[21]}, 32'h0);
        idle("R1");

        // R2: open main mask, then mask slot 9 (bit 7)
        step(3'b0, 16'h0000, 30'h0, '0, 1, 0, 32'h0, 0, 0, "R2");
        step(3'b0, 16'h0100, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R2");      // slot 9
        step(3'b0, 16'h0100, 30'h0, '0, 1, 0, 32'h0000_0080, 0, 0, "R2");
        step(3'b0, 16'h0100, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R2");
        check("R2", "slot 9 masked", {31'd0, status[21]}, 32'h0);
        step(3'b0, 16'h8101, 30'h0, '0, 1, 0, 32'h0, 0, 0, "R4");      // slots 0,9,16

        // R4 / R9: lowest wins, one-clock update
        step(3'b0, 16'h8100, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R4");
        step(3'b0, 16'h8000, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R9");
        step(3'b0, 16'h0010, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R4");      // input bit 4 -> slot 5

        // R3: open peripheral mask, source 30 then mask it; bit 0 of data unused
        step(3'b0, 16'h0, 30'h2000_0000, '0, 1, 1, 32'h0000_0001, 0, 0, "R3");
        step(3'b0, 16'h0, 30'h2000_0000, '0, 0, 0, 32'h0, 0, 0, "R3");
        step(3'b0, 16'h0, 30'h2000_0000, '0, 1, 1, 32'h0000_0002, 0, 0, "R3");
        step(3'b0, 16'h0, 30'h2000_0000, '0, 0, 0, 32'h0, 0, 0, "R3");
        check("R3", "source 30 masked", {31'd0, status[29]}, 32'h0);
        step(3'b0, 16'h0, 30'h0, '0, 1, 1, 32'h0, 0, 0, "R3");

        // R5 / R6: class ordering, cascades, DMA
        step(3'b0, 16'h0, 30'h0008_0010, '0, 0, 0, 32'h0, 0, 0, "R5"); // 5 hi, 20 lo
        step(3'b0, 16'h0, 30'h0008_0800, '0, 0, 0, 32'h0, 0, 0, "R6"); // 12, 20 lo
        step(3'b0, 16'h0, 30'h0008_0800, '0, 1, 0, 32'h0000_1000, 0, 0, "R6"); // mask main 4
        step(3'b0, 16'h0, 30'h0008_0800, '0, 0, 0, 32'h0, 0, 0, "R6");
        step(3'b0, 16'h0, 30'h0000_0040, 16'h0000, 1, 0, 32'h0, 0, 0, "R6"); // 7 hi
        step(3'b0, 16'h0, 30'h0, 16'h0A00, 0, 0, 32'h0, 0, 0, "R5");
        step(3'b0, 16'h0, 30'h0, 16'h8000, 0, 0, 32'h0, 0, 0, "R10");
        step(3'b0, 16'h0, 30'h0, 16'h0000, 0, 0, 32'h0, 0, 0, "R10");
        check("R11", "idle word", status, 32'h0);

        // R7 / R8: latch, no-effect ack, real ack
        step(3'b101, 16'h0, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R7");
        step(3'b101, 16'h0, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R9");       // latency 2
        step(3'b000, 16'h0, 30'h0, '0, 0, 0, 32'h0, 1, 0, "R8");       // ack_crit=0
        step(3'b000, 16'h0, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R8");
        check("R8", "slot 0 still shown", {22'd0, status[10:8]}, 32'h4);
        step(3'b000, 16'h0, 30'h0, '0, 0, 0, 32'h0, 1, 1, "R8");
        step(3'b000, 16'h0, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R8");
        check("R8", "slot 3 shown", {22'd0, status[10:8]}, 32'h7);
        step(3'b000, 16'h0, 30'h0, '0, 0, 0, 32'h0, 1, 1, "R8");
        step(3'b000, 16'h0, 30'h0, '0, 0, 0, 32'h0, 0, 0, "R7");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  c;
            logic [15:0] m;
            logic [29:0] p;
            logic [DMA_N-1:0] d;
            logic [31:0] cd;
            c  = 3'($urandom);
            m  = 16'($urandom & $urandom & $urandom);
            p  = 30'($urandom & $urandom & $urandom);
            d  = ($urandom_range(0, 3) == 0) ? DMA_N'($urandom & $urandom) : '0;
            cd = ($urandom_range(0, 1) == 0) ? $urandom : ($urandom | $urandom);
            step(c, m, p, d, ($urandom_range(0, 7) == 0), 1'($urandom), cd,
                 ($urandom_range(0, 3) == 0), 1'($urandom), "R4 R5 R6 R7 R11");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule